// File: doc/BRIEF.md
# Serial NAND Command Frame Engine

This block produces one complete serial transaction to a serial NAND flash device. A frame starts with one opcode byte. An address phase of zero to three bytes follows, then zero to three dummy bytes, and then an optional data phase. The data phase either transmits or receives, never both. Chip select stays low from the first setup interval through the final hold interval. The clock idles low and both sides are MSB first. The engine drives the clock, clock-low edge to clock-low edge. It samples the input line on each rising clock edge.

A controller starts a frame by presenting a single-cycle request. The request carries the opcode, an address format selector, the raw address bytes, a page (row) number, a column number, the dummy count, a direction flag and a byte count. The engine builds the address bytes itself from the format selector. The format can be raw bytes for register access, a padded row address for array operations, or a column address that carries a plane-select bit for cache access. Write data arrives on a valid/ready stream. Read data leaves on a valid/ready stream. The engine pauses the serial clock whenever a stream is not ready.

Top module: `snand_frame_engine`

## Requirements
- R1: While reset is held and right after it, cs_n is 1, sclk is 0, and busy, done, rx_valid and tx_ready are all 0.
- R2: A frame carries, in this order: the opcode, the address bytes, `req_ndummy` dummy bytes each equal to 0xFF, and then `req_len` data bytes. The total byte count under cs_n low is 1 + address bytes + `req_ndummy` + `req_len`.
- R3: With `req_fmt` = 0 (raw), the frame carries the low `req_naddr` bytes of `req_addr`, most significant byte first. With `req_naddr` = 0 the frame is opcode only.
- R4: With `req_fmt` = 1 (row), the frame carries three address bytes: 0x00, `req_row[15:8]`, `req_row[7:0]`.
- R5: With `req_fmt` = 2 (cache read), the frame carries three address bytes: `req_col[15:8]` with bit 4 ORed with `req_row[6]`, then `req_col[7:0]`, then 0xFF.
- R6: With `req_fmt` = 3 (program load), the frame carries two address bytes: `req_col[15:8]` with bit 4 ORed with `req_row[6]`, then `req_col[7:0]`.
- R7: With `req_rx` = 0, each data byte is taken from `tx_data` on a cycle where both `tx_valid` and `tx_ready` are high, and is sent in stream order. sclk stays low while the engine waits for `tx_valid`.
- R8: With `req_rx` = 1, MOSI carries 0xFF during each data byte. Each byte is assembled MSB first from `miso`, sampled on rising sclk. It is then presented on `rx_data` with `rx_valid` high, and held unchanged until `rx_ready` is seen. The next byte does not start before that.
- R9: sclk is low whenever cs_n is high, and mosi does not change while sclk is high (SPI mode 0).
- R10: From the fall of cs_n to the first rising sclk edge, at least CS_SETUP*2*CLK_DIV clock cycles pass. From the last falling sclk edge to the rise of cs_n, at least CS_HOLD*2*CLK_DIV cycles pass.
- R11: busy rises the cycle after a request is accepted and falls together with the rise of cs_n. done is high for exactly the one cycle after busy falls. A request that arrives while busy is high starts no frame and changes no byte of the running frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_opcode | input | 8 | Command opcode byte |
| req_fmt | input | 2 | Address format: 0 raw, 1 row, 2 cache read, 3 program load |
| req_naddr | input | 2 | Raw-format address byte count (0 to 3) |
| req_addr | input | 24 | Raw-format address bytes, low bytes used |
| req_row | input | 16 | Page number; bit 6 is the plane select |
| req_col | input | 16 | Column (byte offset in page) |
| req_ndummy | input | 2 | Dummy byte count (0 to 3) |
| req_rx | input | 1 | Data direction: 0 transmit, 1 receive |
| req_len | input | LEN_W | Data byte count, 0 for none |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| tx_data | input | 8 | Write data byte |
| tx_valid | input | 1 | Write data available |
| tx_ready | output | 1 | Engine takes tx_data this cycle |
| rx_data | output | 8 | Read data byte |
| rx_valid | output | 1 | Read data available |
| rx_ready | input | 1 | Consumer takes rx_data this cycle |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |

## Verification
Frames are issued in every address format. Each uses its own opcode, row and column values. The plane bit is set in one cache-access frame and clear in another. These frames separate the four formatting rules from each other, and they catch a plane bit taken from the wrong page bit or placed at the wrong column bit. The stimulus also covers an opcode-only frame, a register access of one address byte, and raw three-byte addresses with dummy bytes. These check ordering and byte counting at both extremes of each phase. Transmit and receive frames run both with fully ready streams and with streams that stall often, so a byte lost or repeated around a stall shows up in the compared byte stream. A request injected mid-frame checks that a running frame cannot be disturbed.

// File: rtl/snand_frame_engine.sv
module snand_frame_engine #(
  parameter int CLK_DIV  = 2,
  parameter int CS_SETUP = 1,
  parameter int CS_HOLD  = 1,
  parameter int LEN_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [7:0]       req_opcode,
  input  logic [1:0]       req_fmt,
  input  logic [1:0]       req_naddr,
  input  logic [23:0]      req_addr,
  input  logic [15:0]      req_row,
  input  logic [15:0]      req_col,
  input  logic [1:0]       req_ndummy,
  input  logic             req_rx,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  localparam int SETUP_CYC = CS_SETUP * 2 * CLK_DIV;
  localparam int HOLD_CYC  = CS_HOLD * 2 * CLK_DIV;
  localparam int MAX_CYC   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int TMR_W     = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_LOAD, S_BIT, S_RXW, S_HOLD} state_t;

  state_t           st;
  logic [TMR_W-1:0] tmr;
  logic             ph, rx_mode, cur_rx;
  logic [2:0]       bitc, hcnt;
  logic [7:0]       sh, rsh;
  logic [55:0]      hdr;
  logic [LEN_W-1:0] dcnt;
  logic [23:0]      a_bytes;
  logic [1:0]       a_n;
  logic [7:0]       col_hi;

  assign col_hi = req_col[15:8] | {3'b000, req_row[6], 4'b0000};

  always_comb begin
    a_bytes = 24'hFFFFFF;
    a_n     = 2'd0;
    case (req_fmt)
      2'd0: begin
        a_n = req_naddr;
        case (req_naddr)
          2'd1:    a_bytes = {req_addr[7:0], 16'hFFFF};
          2'd2:    a_bytes = {req_addr[15:0], 8'hFF};
          2'd3:    a_bytes = req_addr;
          default: a_bytes = 24'hFFFFFF;
        endcase
      end
      2'd1: begin a_n = 2'd3; a_bytes = {8'h00, req_row}; end
      2'd2: begin a_n = 2'd3; a_bytes = {col_hi, req_col[7:0], 8'hFF}; end
      default: begin a_n = 2'd2; a_bytes = {col_hi, req_col[7:0], 8'hFF}; end
    endcase
  end

  assign busy     = (st != S_IDLE);
  assign cs_n     = ~busy;
  assign sclk     = ph;
  assign mosi     = sh[7];
  assign tx_ready = (st == S_LOAD) && (hcnt == 3'd0) && (dcnt != '0) && !rx_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tmr      <= '0;
      ph       <= 1'b0;
      bitc     <= 3'd0;
      hcnt     <= 3'd0;
      sh       <= 8'hFF;
      rsh      <= 8'h00;
      hdr      <= '1;
      dcnt     <= '0;
      rx_mode  <= 1'b0;
      cur_rx   <= 1'b0;
      rx_data  <= 8'h00;
      rx_valid <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          hdr     <= {req_opcode, a_bytes, 24'hFFFFFF};
          hcnt    <= 3'd1 + {1'b0, a_n} + {1'b0, req_ndummy};
          dcnt    <= req_len;
          rx_mode <= req_rx;
          tmr     <= TMR_W'(SETUP_CYC - 1);
          st      <= S_SETUP;
        end
        S_SETUP: if (tmr == '0) st <= S_LOAD; else tmr <= tmr - 1'b1;
        S_LOAD: begin
          tmr <= TMR_W'(CLK_DIV - 1);
          if (hcnt != 3'd0) begin
            sh     <= hdr[55:48];
            hdr    <= {hdr[47:0], 8'hFF};
            hcnt   <= hcnt - 3'd1;
            cur_rx <= 1'b0;
            st     <= S_BIT;
          end else if (dcnt != '0) begin
            if (rx_mode) begin
              sh     <= 8'hFF;
              cur_rx <= 1'b1;
              dcnt   <= dcnt - 1'b1;
              st     <= S_BIT;
            end else if (tx_valid) begin
              sh     <= tx_data;
              cur_rx <= 1'b0;
              dcnt   <= dcnt - 1'b1;
              st     <= S_BIT;
            end
          end else begin
            tmr <= TMR_W'(HOLD_CYC - 1);
            st  <= S_HOLD;
          end
        end
        S_BIT: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            tmr <= TMR_W'(CLK_DIV - 1);
            if (!ph) begin
              ph  <= 1'b1;
              rsh <= {rsh[6:0], miso};
            end else begin
              ph <= 1'b0;
              if (bitc == 3'd7) begin
                bitc <= 3'd0;
                if (cur_rx) begin
                  rx_data  <= rsh;
                  rx_valid <= 1'b1;
                  st       <= S_RXW;
                end else st <= S_LOAD;
              end else begin
                bitc <= bitc + 3'd1;
                sh   <= {sh[6:0], 1'b1};
              end
            end
          end
        end
        S_RXW: if (rx_ready) begin
          rx_valid <= 1'b0;
          st       <= S_LOAD;
        end
        S_HOLD: if (tmr == '0) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/snand_frame_engine_chk.sv
module snand_frame_engine_chk #(
  parameter int CLK_DIV  = 2,
  parameter int CS_SETUP = 1,
  parameter int CS_HOLD  = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data
);

  localparam int SETUP_CYC = CS_SETUP * 2 * CLK_DIV;
  localparam int HOLD_CYC  = CS_HOLD * 2 * CLK_DIV;

  logic [15:0] su_cnt, ho_cnt;
  logic        seen_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      su_cnt    <= '0;
      ho_cnt    <= '0;
      seen_rise <= 1'b0;
    end else begin
      if (cs_n) su_cnt <= '0;
      else if (su_cnt != 16'hFFFF) su_cnt <= su_cnt + 1'b1;
      if (sclk) ho_cnt <= '0;
      else if (ho_cnt != 16'hFFFF) ho_cnt <= ho_cnt + 1'b1;
      if (cs_n) seen_rise <= 1'b0;
      else if (sclk) seen_rise <= 1'b1;
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> cs_n && !sclk && !rx_valid);

  a_r9_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r9_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  a_r10_setup_time: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sclk) && !seen_rise) |-> (su_cnt >= 16'(SETUP_CYC)));

  a_r10_hold_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (ho_cnt >= 16'(HOLD_CYC)));

  a_r11_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid && $stable(rx_data));

  a_r7_tx_stall_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && !tx_valid) |=> !sclk);

endmodule

bind snand_frame_engine snand_frame_engine_chk #(
  .CLK_DIV(CLK_DIV), .CS_SETUP(CS_SETUP), .CS_HOLD(CS_HOLD)
) u_chk (.*);

// File: tb/test_snand_frame_engine.sv
module test_snand_frame_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 3;
  localparam int SU  = 2;
  localparam int HO  = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rx = 1'b0;
  logic [7:0] req_opcode = 8'h00;
  logic [1:0] req_fmt = 2'd0, req_naddr = 2'd0, req_ndummy = 2'd0;
  logic [23:0] req_addr = 24'h0;
  logic [15:0] req_row = 16'h0, req_col = 16'h0;
  logic [11:0] req_len = 12'd0;
  logic busy, done, tx_ready, rx_valid, sclk, cs_n, mosi;
  logic [7:0] tx_data = 8'h00, rx_data;
  logic tx_valid = 1'b0, rx_ready = 1'b0, miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snand_frame_engine #(.CLK_DIV(DIV), .CS_SETUP(SU), .CS_HOLD(HO), .LEN_W(12)) i_snand_frame_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_fmt(req_fmt), .req_naddr(req_naddr), .req_addr(req_addr), .req_row(req_row),
    .req_col(req_col), .req_ndummy(req_ndummy), .req_rx(req_rx), .req_len(req_len),
    .busy(busy), .done(done), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'(k * 29 + 8'h47);
  endfunction

  logic [7:0] exp_mosi[$];
  string      exp_tag[$];
  logic [7:0] exp_rx[$];
  logic [7:0] tx_q[$];

  // flash-side model: shifts in MOSI, returns resp(k) for frame byte k
  logic [7:0] mb = 8'h00, cur = 8'h00;
  int nb = 0, fb = 0, frames = 0;
  bit got_rise = 0;
  time t_csf = 0, t_rise = 0, t_fall = 0, t_csr = 0;

  always @(negedge cs_n) begin
    nb = 0; fb = 0; cur = resp(0); miso = cur[7];
    frames++; t_csf = $time; got_rise = 0;
  end
  always @(posedge cs_n) t_csr = $time;

  always @(posedge sclk) if (!cs_n) begin
    if (!got_rise) begin t_rise = $time; got_rise = 1; end
    mb = {mb[6:0], mosi};
    nb++;
    if (nb == 8) begin
      nb = 0;
      fb++;
      if (exp_mosi.size() == 0) chk(0, "R2 extra byte", mb, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_mosi.pop_front();
        t = exp_tag.pop_front();
        chk(mb == e, t, mb, e);
      end
    end
  end

  always @(negedge sclk) if (!cs_n) begin
    t_fall = $time;
    if (nb == 0) cur = resp(fb);
    miso = cur[7 - nb];
  end

  // stream drivers and read monitor (away from the active edge)
  bit stall = 0, tx_took = 0, held = 0;
  logic [7:0] held_d;
  int gap = 0;

  always @(negedge clk) begin
    gap++;
    if (tx_took) void'(tx_q.pop_front());
    tx_valid = (tx_q.size() > 0) && (!stall || gap % 3 == 0);
    tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    tx_took  = tx_valid && tx_ready;
    rx_ready = !stall || (gap % 4 == 0);
    if (rx_valid) begin
      if (held) chk(rx_data == held_d, "R8 rx_data held", rx_data, held_d);
      if (rx_ready) begin
        held = 0;
        if (exp_rx.size() == 0) chk(0, "R8 extra rx byte", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R8 rx data", rx_data, e);
        end
      end else begin
        held = 1; held_d = rx_data;
      end
    end
  end

  task automatic push(input logic [7:0] b, input string t);
    exp_mosi.push_back(b);
    exp_tag.push_back(t);
  endtask

  task automatic send(input logic [7:0] op, input logic [1:0] fmt, input logic [1:0] na,
                      input logic [23:0] addr, input logic [15:0] row, input logic [15:0] col,
                      input logic [1:0] nd, input bit rx, input int len, input bit stl, input bit poke);
    logic [7:0] hi;
    int hn, f0;
    hi = col[15:8] | (row[6] ? 8'h10 : 8'h00);
    push(op, "R2 opcode");
    case (fmt)
      2'd0: begin
        for (int i = 0; i < int'(na); i++) push(addr[8*(int'(na)-1-i) +: 8], "R3 raw address");
        hn = 1 + int'(na);
      end
      2'd1: begin push(8'h00, "R4 row pad"); push(row[15:8], "R4 row high"); push(row[7:0], "R4 row low"); hn = 4; end
      2'd2: begin push(hi, "R5 column high"); push(col[7:0], "R5 column low"); push(8'hFF, "R5 filler"); hn = 4; end
      default: begin push(hi, "R6 column high"); push(col[7:0], "R6 column low"); hn = 3; end
    endcase
    for (int i = 0; i < int'(nd); i++) push(8'hFF, "R2 dummy");
    hn = hn + int'(nd);
    for (int i = 0; i < len; i++) begin
      if (rx) begin
        push(8'hFF, "R8 read filler");
        exp_rx.push_back(resp(hn + i));
      end else begin
        logic [7:0] b;
        b = 8'(8'h5A ^ (i * 7) ^ op);
        tx_q.push_back(b);
        push(b, "R7 tx data");
      end
    end
    stall = stl;
    f0 = frames;
    @(negedge clk);
    req_opcode = op; req_fmt = fmt; req_naddr = na; req_addr = addr; req_row = row;
    req_col = col; req_ndummy = nd; req_rx = rx; req_len = 12'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, "R11 busy after accept", busy, 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      req_opcode = 8'hEE; req_fmt = 2'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(done && cs_n, "R11 done as busy falls", {done, cs_n}, 2'b11);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    chk(frames == f0 + 1, "R11 one frame per request", frames - f0, 1);
    chk(fb == hn + len, "R2 byte count", fb, hn + len);
    chk(exp_mosi.size() == 0, "R2 bytes missing", exp_mosi.size(), 0);
    chk(exp_rx.size() == 0, "R8 rx bytes missing", exp_rx.size(), 0);
    chk(t_rise - t_csf >= SU*2*DIV*CLK_PERIOD, "R10 setup", 32'(t_rise - t_csf), SU*2*DIV*CLK_PERIOD);
    chk(t_csr - t_fall >= HO*2*DIV*CLK_PERIOD, "R10 hold", 32'(t_csr - t_fall), HO*2*DIV*CLK_PERIOD);
    exp_mosi.delete(); exp_tag.delete(); exp_rx.delete(); tx_q.delete();
    repeat (15) @(negedge clk);
    chk(frames == f0 + 1 && cs_n && !sclk, "R11 ignored request", frames - f0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && !rx_valid && !tx_ready, "R1 reset state",
        {cs_n, sclk, busy, done, rx_valid, tx_ready}, 6'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done, "R1 after reset", {cs_n, sclk, busy, done}, 4'b1000);
    send(8'h0F, 2'd0, 2'd1, 24'h0000C0, 16'h0, 16'h0, 2'd0, 1, 1, 0, 0);    // R3 register read
    send(8'h1F, 2'd0, 2'd1, 24'h0000A0, 16'h0, 16'h0, 2'd0, 0, 1, 0, 0);    // R3 register write
    send(8'h9F, 2'd0, 2'd0, 24'h0, 16'h0, 16'h0, 2'd0, 1, 3, 0, 0);         // R3 opcode only + 3 rx
    send(8'h06, 2'd0, 2'd0, 24'h0, 16'h0, 16'h0, 2'd0, 0, 0, 0, 0);         // R2 opcode only frame
    send(8'h13, 2'd1, 2'd0, 24'h0, 16'h1234, 16'h0, 2'd0, 0, 0, 0, 0);      // R4 page read
    send(8'hD8, 2'd1, 2'd0, 24'h0, 16'h00C0, 16'h0, 2'd0, 0, 0, 0, 0);      // R4 erase
    send(8'h03, 2'd2, 2'd0, 24'h0, 16'h0040, 16'h0805, 2'd0, 1, 6, 1, 0);   // R5 plane 1, stalled rx
    send(8'h03, 2'd2, 2'd0, 24'h0, 16'h00BF, 16'h0800, 2'd0, 1, 4, 0, 0);   // R5 plane 0
    send(8'h0B, 2'd2, 2'd0, 24'h0, 16'h0041, 16'h0123, 2'd1, 1, 2, 0, 0);   // R5 with dummy
    send(8'h84, 2'd3, 2'd0, 24'h0, 16'h0041, 16'h0123, 2'd0, 0, 5, 1, 0);   // R6 stalled tx
    send(8'h84, 2'd3, 2'd0, 24'h0, 16'h0000, 16'h08FF, 2'd0, 0, 3, 0, 0);   // R6 plane 0
    send(8'h77, 2'd0, 2'd3, 24'hA1B2C3, 16'h0, 16'h0, 2'd2, 0, 4, 0, 1);    // R3/R11 raw 3 + dummy, poke
    send(8'h5B, 2'd0, 2'd2, 24'h00F00D, 16'h0, 16'h0, 2'd3, 1, 2, 1, 0);    // R2 three dummies
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule